// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Per-Address Flush

This block is a small read cache placed between a CPU load port and a slower word-addressed main memory. It keeps eight lines, and each line holds one 32-bit word. Each line is a single 60-bit storage entry that packs a valid flag, a 27-bit address tag and the data word. The index bits are not stored in the tag, because the incoming address already supplies them.

A read that finds its word answers on the next cycle. A read that misses raises a memory request with the word address and holds it until memory acknowledges with the data. The cache then writes the line and returns the word. A flush command names an address. It invalidates the indexed line only when that line currently holds that address.

Only whole-word reads are served, so the two lowest address bits play no part. Writes, multi-word lines and associativity are not part of this block.

Top module: `dmCache`

## Requirements
- R1: After reset every line is empty. `memReq` and `cpuRespValid` are 0 and `cpuReady` is 1, and the first read of any address misses.
- R2: Address bits [4:2] select the line and bits [31:5] form the stored tag. Eight consecutive words, once loaded, all hit, and so does an address whose top bits are all ones.
- R3: Address bits [1:0] are ignored. A read whose only difference from a cached word is in bits [1:0] hits and returns that word.
- R4: A read that hits shows `cpuRespValid`=1, `cpuRespHit`=1 and the stored word in the cycle after the request is accepted (`cpuReq` and `cpuReady` both 1 at a clock edge). No memory request is raised.
- R5: A read that misses raises `memReq` in the cycle after acceptance, with `memAddr` = address bits [31:2]. Both hold steady until `memAck`.
- R6: In the cycle after `memAck` the block shows `cpuRespValid`=1, `cpuRespHit`=0 and `cpuRespData` equal to the acknowledged `memData`. The line is filled, so the next read of that word hits.
- R7: `cpuReady` is 0 while a miss is outstanding (`memReq`=1).
- R8: A flush of an address whose line holds that address clears the line, and the next read of it misses.
- R9: A flush of an address that shares a line index with the cached word but has a different tag leaves the line unchanged, and the next read still hits.
- R10: Two addresses with the same index and different tags evict each other, so alternating reads of them miss every time.
- R11: When `flushReq` and `cpuReq` are both high in the idle state, the flush is taken and `cpuReady` is 0 in that cycle. The read is accepted in the following cycle and sees the flushed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU read request |
| cpuAddr | input | 32 | CPU byte address |
| cpuReady | output | 1 | Request is accepted at this edge if `cpuReq` is high |
| cpuRespValid | output | 1 | One-cycle response strobe |
| cpuRespHit | output | 1 | Response came from the cache rather than from memory |
| cpuRespData | output | 32 | Response word |
| flushReq | input | 1 | Flush command |
| flushAddr | input | 32 | Byte address to flush |
| flushReady | output | 1 | Flush is taken at this edge if `flushReq` is high |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | 30 | Word address for memory |
| memAck | input | 1 | Memory returns data this cycle |
| memData | input | 32 | Memory read data |

## Verification
The assertions check handshake behaviour on every cycle:
- an accepted read turns into either a hit response or a memory request for the right word address on the next cycle;
- a memory request and its address stay put until acknowledged;
- the CPU port stays closed during a miss and during a taken flush;
- an acknowledge is followed by a miss response that carries the memory word.

Only the bench's scenarios can show what the stored lines contain. These are:
- that neighbouring words live side by side;
- that byte offsets alias to one word;
- that a flush spares a line with another tag;
- that conflicting addresses keep evicting each other.

// File: rtl/dmCachePkg.sv
package dmCachePkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MISS = 1'b1
  } ctrlStateT;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic flush;    // invalidate indexed line if tag matches
    logic loadHit;  // load response register from the looked-up line
    logic capture;  // latch the missing request address
    logic fill;     // write line from memory and load response
  } strobesT;

endpackage

// File: rtl/cacheLine.sv
module cacheLine #(
  parameter int TAG_W  = 27,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  input  logic              invEn,
  input  logic [TAG_W-1:0]  invTag,
  output logic              lineValid,
  output logic [TAG_W-1:0]  lineTag,
  output logic [DATA_W-1:0] lineData
);
  localparam int ENTRY_W = 1 + TAG_W + DATA_W;
  localparam int V_BIT   = ENTRY_W - 1;

  // Packed entry: {valid, tag, data}
  logic [ENTRY_W-1:0] entry;

  assign lineValid = entry[V_BIT];
  assign lineTag   = entry[DATA_W +: TAG_W];
  assign lineData  = entry[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entry <= '0;
    end else if (wrEn) begin
      entry <= {1'b1, wrTag, wrData};
    end else if (invEn && (lineTag == invTag)) begin
      entry[V_BIT] <= 1'b0;
    end
  end

endmodule

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import dmCachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobesT                         st,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [ADDR_W-1:0]               flushAddr,
  input  logic [DATA_W-1:0]               memData,
  output logic                            lookupHit,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [DATA_W-1:0]               cpuRespData
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] pendAddr;

  logic [IDX_W-1:0] lkIdx, flIdx, fillIdx;
  logic [TAG_W-1:0] lkTag, flTag, fillTag;

  assign lkIdx   = cpuAddr[OFF_W +: IDX_W];
  assign lkTag   = cpuAddr[ADDR_W-1 -: TAG_W];
  assign flIdx   = flushAddr[OFF_W +: IDX_W];
  assign flTag   = flushAddr[ADDR_W-1 -: TAG_W];
  assign fillIdx = pendAddr[OFF_W +: IDX_W];
  assign fillTag = pendAddr[ADDR_W-1 -: TAG_W];

  logic              lineValid [LINES];
  logic [TAG_W-1:0]  lineTag   [LINES];
  logic [DATA_W-1:0] lineData  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : gLine
    logic wrEn, invEn;
    assign wrEn  = st.fill  && (fillIdx == IDX_W'(i));
    assign invEn = st.flush && (flIdx   == IDX_W'(i));

    cacheLine #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
    ) uLine (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (wrEn),
      .wrTag    (fillTag),
      .wrData   (memData),
      .invEn    (invEn),
      .invTag   (flTag),
      .lineValid(lineValid[i]),
      .lineTag  (lineTag[i]),
      .lineData (lineData[i])
    );
  end

  assign lookupHit = lineValid[lkIdx] && (lineTag[lkIdx] == lkTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
    end else if (st.capture) begin
      pendAddr <= cpuAddr;
    end
  end

  assign memAddr = pendAddr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRespData <= '0;
    end else if (st.fill) begin
      cpuRespData <= memData;
    end else if (st.loadHit) begin
      cpuRespData <= lineData[lkIdx];
    end
  end

endmodule

// File: rtl/cacheCtrl.sv
module cacheCtrl
  import dmCachePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    flushReq,
  input  logic    memAck,
  input  logic    lookupHit,
  output strobesT st,
  output logic    cpuReady,
  output logic    flushReady,
  output logic    memReq,
  output logic    cpuRespValid,
  output logic    cpuRespHit
);
  ctrlStateT state;
  logic      isIdle, accept;

  assign isIdle     = (state == ST_IDLE);
  assign flushReady = isIdle;
  // A pending flush takes the cycle; the read waits one cycle
  assign cpuReady   = isIdle && !flushReq;
  assign accept     = cpuReady && cpuReq;
  assign memReq     = (state == ST_MISS);

  always_comb begin
    st         = '0;
    st.flush   = isIdle && flushReq;
    st.loadHit = accept && lookupHit;
    st.capture = accept && !lookupHit;
    st.fill    = memReq && memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cpuRespValid <= 1'b0;
      cpuRespHit   <= 1'b0;
    end else begin
      cpuRespValid <= st.loadHit || st.fill;
      cpuRespHit   <= st.loadHit;
      unique case (state)
        ST_IDLE: if (st.capture) state <= ST_MISS;
        ST_MISS: if (memAck)     state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dmCache.sv
module dmCache
  import dmCachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cpuReq,
  input  logic [ADDR_W-1:0]                  cpuAddr,
  output logic                               cpuReady,
  output logic                               cpuRespValid,
  output logic                               cpuRespHit,
  output logic [DATA_W-1:0]                  cpuRespData,
  input  logic                               flushReq,
  input  logic [ADDR_W-1:0]                  flushAddr,
  output logic                               flushReady,
  output logic                               memReq,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  input  logic                               memAck,
  input  logic [DATA_W-1:0]                  memData
);
  strobesT st;
  logic    lookupHit;

  cacheCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .flushReq    (flushReq),
    .memAck      (memAck),
    .lookupHit   (lookupHit),
    .st          (st),
    .cpuReady    (cpuReady),
    .flushReady  (flushReady),
    .memReq      (memReq),
    .cpuRespValid(cpuRespValid),
    .cpuRespHit  (cpuRespHit)
  );

  cacheDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cpuAddr    (cpuAddr),
    .flushAddr  (flushAddr),
    .memData    (memData),
    .lookupHit  (lookupHit),
    .memAddr    (memAddr),
    .cpuRespData(cpuRespData)
  );

endmodule

// File: rtl/dmCacheChk.sv
module dmCacheChk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               cpuReq,
  input logic [ADDR_W-1:0]                  cpuAddr,
  input logic                               cpuReady,
  input logic                               cpuRespValid,
  input logic                               cpuRespHit,
  input logic [DATA_W-1:0]                  cpuRespData,
  input logic                               flushReq,
  input logic [ADDR_W-1:0]                  flushAddr,
  input logic                               flushReady,
  input logic                               memReq,
  input logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  input logic                               memAck,
  input logic [DATA_W-1:0]                  memData
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady) |=> ((cpuRespValid && cpuRespHit) ||
      (memReq && !cpuRespValid && memAddr == $past(cpuAddr[ADDR_W-1:OFF_W])))); // R5

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))); // R5

  AST_FILL_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (cpuRespValid && !cpuRespHit &&
      cpuRespData == $past(memData))); // R6

  AST_CLOSED_DURING_MISS: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady); // R7

  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && flushReady) |-> !cpuReady); // R11

  AST_HIT_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRespValid && cpuRespHit) |-> !memReq); // R4

endmodule

bind dmCache dmCacheChk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LINES (LINES)
) uChk (.*);

// File: tb/sim_dmCache.sv
`timescale 1ns/1ps
module sim_dmCache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuReady, cpuRespValid, cpuRespHit;
  logic [31:0] cpuRespData;
  logic        flushReq = 1'b0;
  logic [31:0] flushAddr = '0;
  logic        flushReady;
  logic        memReq;
  logic [29:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  int memLat = 2;

  always #5 clk = ~clk;

  dmCache u0 (.*);

  function automatic logic [31:0] memWord(input logic [29:0] wa);
    return ({2'b0, wa} * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: acknowledges after memLat waiting cycles
  initial begin
    int waitCnt = 0;
    logic [29:0] heldAddr = '0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq) begin
        if (waitCnt == 0) heldAddr = memAddr;
        else chk(memAddr == heldAddr, "R5", "memAddr stable", {2'b0, memAddr}, {2'b0, heldAddr});
        chk(!cpuReady, "R7", "cpuReady during miss", {31'b0, cpuReady}, 32'h0);
        if (waitCnt >= memLat) begin
          memAck  = 1'b1;
          memData = memWord(memAddr);
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  // Issue one read and check hit/miss, handshake timing and data
  task automatic doRead(input logic [31:0] addr, input bit expHit, input string req);
    bit acc;
    int guard;
    @(negedge clk);
    cpuReq  = 1'b1;
    cpuAddr = addr;
    acc = 1'b0;
    while (!acc) begin
      #1 acc = cpuReady;
      @(negedge clk);
    end
    cpuReq = 1'b0;
    if (expHit) begin
      chk(cpuRespValid && cpuRespHit, req, "hit response next cycle",
          {30'b0, cpuRespValid, cpuRespHit}, 32'h3);
      chk(cpuRespData == memWord(addr[31:2]), req, "hit data", cpuRespData, memWord(addr[31:2]));
      chk(!memReq, req, "no memReq on hit", {31'b0, memReq}, 32'h0);
    end else begin
      chk(memReq && !cpuRespValid, req, "miss raises memReq",
          {30'b0, memReq, cpuRespValid}, 32'h2);
      chk(memAddr == addr[31:2], "R5", "memAddr word address", {2'b0, memAddr}, {2'b0, addr[31:2]});
      guard = 0;
      while (!cpuRespValid && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      chk(cpuRespValid && !cpuRespHit, "R6", "fill response", {30'b0, cpuRespValid, cpuRespHit}, 32'h2);
      chk(cpuRespData == memWord(addr[31:2]), "R6", "fill data", cpuRespData, memWord(addr[31:2]));
    end
  endtask

  task automatic doFlush(input logic [31:0] addr);
    @(negedge clk);
    flushReq  = 1'b1;
    flushAddr = addr;
    @(negedge clk);
    flushReq = 1'b0;
  endtask

  task automatic tReset();
    chk(!memReq && !cpuRespValid && cpuReady, "R1", "idle outputs after reset",
        {29'b0, memReq, cpuRespValid, cpuReady}, 32'h1);
    doRead(32'h0000_0100, 1'b0, "R1");
  endtask

  task automatic tNeighbours();
    for (int i = 0; i < 8; i++) doRead(32'h0000_0040 + 32'(4 * i), 1'b0, "R2");
    for (int i = 0; i < 8; i++) doRead(32'h0000_0040 + 32'(4 * i), 1'b1, "R4");
    doRead(32'hFFFF_FFFC, 1'b0, "R2");
    doRead(32'hFFFF_FFFC, 1'b1, "R2");
  endtask

  task automatic tOffset();
    doRead(32'h0000_0045, 1'b1, "R3");
    doRead(32'h0000_0057, 1'b1, "R3");
  endtask

  task automatic tFlushMatch();
    doFlush(32'h0000_004B);
    doRead(32'h0000_0048, 1'b0, "R8");
    doRead(32'h0000_0048, 1'b1, "R6");
  endtask

  task automatic tFlushOther();
    doFlush(32'h0000_1048);
    doRead(32'h0000_0048, 1'b1, "R9");
  endtask

  task automatic tConflict();
    for (int k = 0; k < 3; k++) begin
      doRead(32'h0000_2000, 1'b0, "R10");
      doRead(32'h0000_4000, 1'b0, "R10");
    end
  endtask

  task automatic tCollide();
    doRead(32'h0000_0050, 1'b1, "R11");
    @(negedge clk);
    cpuReq    = 1'b1;
    cpuAddr   = 32'h0000_0050;
    flushReq  = 1'b1;
    flushAddr = 32'h0000_0050;
    #1 chk(!cpuReady && flushReady, "R11", "flush takes the cycle",
           {30'b0, cpuReady, flushReady}, 32'h1);
    @(negedge clk);
    flushReq = 1'b0;
    chk(!cpuRespValid && !memReq, "R11", "read not taken with flush",
        {30'b0, cpuRespValid, memReq}, 32'h0);
    #1 chk(cpuReady, "R11", "read accepted next cycle", {31'b0, cpuReady}, 32'h1);
    @(negedge clk);
    cpuReq = 1'b0;
    chk(memReq && !cpuRespValid, "R11", "read sees flushed line",
        {30'b0, memReq, cpuRespValid}, 32'h2);
    while (!cpuRespValid) @(negedge clk);
    chk(cpuRespData == memWord(30'h14), "R11", "refill data", cpuRespData, memWord(30'h14));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNeighbours();
    tOffset();
    tFlushMatch();
    tFlushOther();
    tConflict();
    memLat = 0;
    tCollide();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule